// File: doc/BRIEF.md
# Host Port Mailbox Interface

This block is a 16-bit parallel slave port. An external processor uses it to trade data with an on-chip CPU. The external side has a chip select, a read strobe, a write strobe, two address pins and a 16-bit data bus, with the input and output directions kept separate. The two address pins select one of four port registers:

- a data window into on-chip memory, with an address pointer that steps by one word;
- a mailbox;
- the pointer itself;
- a status word.

On the internal side there are three ports:

- a simple word-wide memory port, which returns read data one cycle after a read request;
- a small indexed register port, which the CPU uses for its mailboxes, message flag and control bits;
- a set of interrupt outputs.

The external strobes are asynchronous to the core clock. Each is passed through a flop synchroniser. An access takes effect when its strobe is released. The block keeps a prefetched copy of the word at the pointer, so a host read of the data window returns at once. A control field can exchange the two byte lanes on the external bus. A routing bit sends a bus-voltage change event either to the host interrupt line or to the CPU.

Top module: `hpi_mbox_top`

## Requirements
- R1: Host address 00 selects the data window, 01 the mailbox, 10 the word pointer and 11 the status word, for both reads and writes; the status word reads as zero in every bit not listed in R7.
- R2: A host write to the data window stores the word at the pointer in memory, and every host data read or write then advances the pointer by one, wrapping from 2^AW-1 to 0; a host write to address 10 loads the pointer from the low AW data bits.
- R3: A host read of the data window returns the memory word at the current pointer, including straight after the pointer was loaded.
- R4: A CPU write to register index 0 (outbound mailbox) raises hp_irq; a host read of address 01 returns that word and drops hp_irq.
- R5: cpu_txe_irq is low after reset, rises when the host reads address 01, and falls when the CPU writes index 0.
- R6: A host write to address 01 sets the inbound-full flag and cpu_mbx_irq; a CPU read of index 1 returns the word and clears both.
- R7: Status word bits: 0 outbound pending, 1 inbound full, 2 message flag, 3 bus-voltage event for the host. A CPU write to index 2 sets the message flag, and a host read of address 11 clears it.
- R8: Control index 3 bits [1:0] select the byte lanes. 11 exchanges the high and low bytes of every word crossing the external bus in either direction, and 00, 01 and 10 leave them in place; the reset value is 00.
- R9: With control bit 2 set, a vbus_evt pulse raises hp_irq and status bit 3, and both clear on a host read of address 11. With bit 2 clear, the pulse raises cpu_vbus_irq, which clears on a CPU read of index 4 (status word), and hp_irq stays low.
- R10: Strobes with hp_cs_n high have no effect, and hp_dout_en is high only while hp_cs_n and hp_rd_n are both low.
- R11: After reset hp_irq, cpu_mbx_irq, cpu_txe_irq and cpu_vbus_irq are low, the pointer, control and status words read as zero, and hp_dout_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_cs_n | input | 1 | Host chip select, active low |
| hp_rd_n | input | 1 | Host read strobe, active low |
| hp_wr_n | input | 1 | Host write strobe, active low |
| hp_addr | input | 2 | Host register select |
| hp_din | input | 16 | Host write data |
| hp_dout | output | 16 | Host read data |
| hp_dout_en | output | 1 | Host bus output enable |
| hp_irq | output | 1 | Interrupt toward the host |
| mem_addr | output | AW | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read request |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after mem_re |
| cpu_wr | input | 1 | CPU register write pulse |
| cpu_rd | input | 1 | CPU register read pulse |
| cpu_idx | input | 3 | CPU register index |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU read data, combinational |
| cpu_mbx_irq | output | 1 | Inbound mailbox full |
| cpu_txe_irq | output | 1 | Outbound mailbox taken by host |
| cpu_vbus_irq | output | 1 | Bus-voltage event for the CPU |
| vbus_evt | input | 1 | Single-cycle bus-voltage change pulse |

## Verification
The assertions assume a host that is well behaved:

- It never asserts both strobes at once.
- It holds the address and write data steady from the first strobe edge until a few core cycles after the strobe is released.
- It leaves enough idle time between accesses for the prefetch to settle.

The CPU port is assumed to issue at most one read or write per cycle. The bench stays within these limits. It drives the host pins through tasks with fixed strobe widths and gaps of several clock cycles, and it pulses vbus_evt and the CPU strobes for exactly one cycle, away from any host access.

// File: rtl/hpi_pkg.sv
package hpi_pkg;

  // Host-side register select, decoded from the two address pins
  typedef enum logic [1:0] {
    HSEL_DATA = 2'b00,
    HSEL_MBX  = 2'b01,
    HSEL_PTR  = 2'b10,
    HSEL_STAT = 2'b11
  } hsel_e;

  // CPU-side register indices
  localparam int          CIDX_W      = 3;
  localparam logic [2:0]  CIDX_OUTBOX = 3'd0;
  localparam logic [2:0]  CIDX_INBOX  = 3'd1;
  localparam logic [2:0]  CIDX_MSG    = 3'd2;
  localparam logic [2:0]  CIDX_CTRL   = 3'd3;
  localparam logic [2:0]  CIDX_STAT   = 3'd4;

  // Status word bit positions
  localparam int ST_OUT  = 0;
  localparam int ST_IN   = 1;
  localparam int ST_MSG  = 2;
  localparam int ST_VBUS = 3;

  // Control word layout
  localparam int            CTRL_ROUTE = 2;
  localparam logic [15:0]   CTRL_MASK  = 16'h0007;

  // Byte-lane exchange: only code 11 swaps
  function automatic logic [15:0] lane_swap(input logic [15:0] w,
                                            input logic [1:0]  mode);
    return (mode == 2'b11) ? {w[7:0], w[15:8]} : w;
  endfunction

endpackage

// File: rtl/hpi_strobe_sync.sv
module hpi_strobe_sync #(
  parameter int STAGES = 2,
  parameter int NSIG   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSIG-1:0] async_i,
  output logic [NSIG-1:0] sync_o
);

  logic [NSIG-1:0] chain_q [STAGES];

  // Reset to all ones: host strobes are inactive high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '1;
    end else begin
      chain_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/hpi_mem_seq.sv
module hpi_mem_seq #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_wr,
  input  logic          data_rd,
  input  logic          ptr_wr,
  input  logic [15:0]   wdata,
  output logic [AW-1:0] ptr,
  output logic [15:0]   rd_buf,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata
);

  logic [AW-1:0] ptr_q, ptr_d;
  logic          pend_q, pend_d;
  logic          wait_q, wait_d;
  logic [15:0]   buf_q, buf_d;

  // Next state: a host event has priority over the prefetch, which is retried
  always_comb begin
    ptr_d     = ptr_q;
    pend_d    = pend_q;
    wait_d    = 1'b0;
    buf_d     = buf_q;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = ptr_q;
    mem_wdata = wdata;
    if (wait_q) buf_d = mem_rdata;
    if (ptr_wr) begin
      ptr_d  = wdata[AW-1:0];
      pend_d = 1'b1;
    end else if (data_wr) begin
      mem_we = 1'b1;
      ptr_d  = ptr_q + AW'(1);
      pend_d = 1'b1;
    end else if (data_rd) begin
      ptr_d  = ptr_q + AW'(1);
      pend_d = 1'b1;
    end else if (pend_q) begin
      mem_re = 1'b1;
      pend_d = 1'b0;
      wait_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      pend_q <= 1'b1;
      wait_q <= 1'b0;
      buf_q  <= '0;
    end else begin
      ptr_q  <= ptr_d;
      pend_q <= pend_d;
      wait_q <= wait_d;
      buf_q  <= buf_d;
    end
  end

  assign ptr    = ptr_q;
  assign rd_buf = buf_q;

endmodule

// File: rtl/hpi_mbox_regs.sv
module hpi_mbox_regs
  import hpi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_mbx_wr,
  input  logic              h_mbx_rd,
  input  logic              h_stat_rd,
  input  logic [15:0]       h_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [CIDX_W-1:0] cpu_idx,
  input  logic [15:0]       cpu_wdata,
  output logic [15:0]       cpu_rdata,
  input  logic              vbus_evt,
  output logic [15:0]       out_mbx,
  output logic [15:0]       stat_word,
  output logic [1:0]        swap_mode,
  output logic              route_on,
  output logic              hp_irq,
  output logic              cpu_mbx_irq,
  output logic              cpu_txe_irq,
  output logic              cpu_vbus_irq
);

  logic [15:0] out_q, out_d, in_q, in_d, ctrl_q, ctrl_d;
  logic        ofull_q, ofull_d, ifull_q, ifull_d, msg_q, msg_d;
  logic        txe_q, txe_d, vbh_q, vbh_d, vbc_q, vbc_d;
  logic        cw_out, cw_msg, cw_ctrl, cr_in, cr_stat;

  assign cw_out  = cpu_wr && (cpu_idx == CIDX_OUTBOX);
  assign cw_msg  = cpu_wr && (cpu_idx == CIDX_MSG);
  assign cw_ctrl = cpu_wr && (cpu_idx == CIDX_CTRL);
  assign cr_in   = cpu_rd && (cpu_idx == CIDX_INBOX);
  assign cr_stat = cpu_rd && (cpu_idx == CIDX_STAT);

  // Next state: a setting event wins over a clearing event in the same cycle
  always_comb begin
    out_d   = cw_out ? cpu_wdata : out_q;
    ofull_d = cw_out ? 1'b1 : (h_mbx_rd ? 1'b0 : ofull_q);
    txe_d   = cw_out ? 1'b0 : (h_mbx_rd ? 1'b1 : txe_q);
    in_d    = h_mbx_wr ? h_wdata : in_q;
    ifull_d = h_mbx_wr ? 1'b1 : (cr_in ? 1'b0 : ifull_q);
    msg_d   = cw_msg ? 1'b1 : (h_stat_rd ? 1'b0 : msg_q);
    vbh_d   = (vbus_evt && route_on)  ? 1'b1 : (h_stat_rd ? 1'b0 : vbh_q);
    vbc_d   = (vbus_evt && !route_on) ? 1'b1 : (cr_stat ? 1'b0 : vbc_q);
    ctrl_d  = cw_ctrl ? (cpu_wdata & CTRL_MASK) : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      in_q    <= '0;
      ctrl_q  <= '0;
      ofull_q <= 1'b0;
      ifull_q <= 1'b0;
      msg_q   <= 1'b0;
      txe_q   <= 1'b0;
      vbh_q   <= 1'b0;
      vbc_q   <= 1'b0;
    end else begin
      out_q   <= out_d;
      in_q    <= in_d;
      ctrl_q  <= ctrl_d;
      ofull_q <= ofull_d;
      ifull_q <= ifull_d;
      msg_q   <= msg_d;
      txe_q   <= txe_d;
      vbh_q   <= vbh_d;
      vbc_q   <= vbc_d;
    end
  end

  always_comb begin
    stat_word          = '0;
    stat_word[ST_OUT]  = ofull_q;
    stat_word[ST_IN]   = ifull_q;
    stat_word[ST_MSG]  = msg_q;
    stat_word[ST_VBUS] = vbh_q;
  end

  always_comb begin
    case (cpu_idx)
      CIDX_OUTBOX: cpu_rdata = out_q;
      CIDX_INBOX:  cpu_rdata = in_q;
      CIDX_CTRL:   cpu_rdata = ctrl_q;
      CIDX_STAT:   cpu_rdata = stat_word;
      default:     cpu_rdata = '0;
    endcase
  end

  assign out_mbx      = out_q;
  assign swap_mode    = ctrl_q[1:0];
  assign route_on     = ctrl_q[CTRL_ROUTE];
  assign hp_irq       = ofull_q | vbh_q;
  assign cpu_mbx_irq  = ifull_q;
  assign cpu_txe_irq  = txe_q;
  assign cpu_vbus_irq = vbc_q;

endmodule

// File: rtl/hpi_mbox_top.sv
module hpi_mbox_top
  import hpi_pkg::*;
#(
  parameter int AW          = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hp_cs_n,
  input  logic          hp_rd_n,
  input  logic          hp_wr_n,
  input  logic [1:0]    hp_addr,
  input  logic [15:0]   hp_din,
  output logic [15:0]   hp_dout,
  output logic          hp_dout_en,
  output logic          hp_irq,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [2:0]    cpu_idx,
  input  logic [15:0]   cpu_wdata,
  output logic [15:0]   cpu_rdata,
  output logic          cpu_mbx_irq,
  output logic          cpu_txe_irq,
  output logic          cpu_vbus_irq,
  input  logic          vbus_evt
);

  localparam int NSTRB = 3;

  logic [NSTRB-1:0] strb_s;
  logic             rd_act, wr_act, rd_act_q, wr_act_q;
  logic [1:0]       cap_addr_q, cap_addr_d;
  logic [15:0]      cap_din_q, cap_din_d;
  logic             h_rd_evt, h_wr_evt;
  hsel_e            h_sel;
  logic [15:0]      h_wdata;
  logic [1:0]       swap_mode;
  logic             route_on;
  logic [AW-1:0]    ptr;
  logic [15:0]      rd_buf, out_mbx, stat_word, rmux;

  hpi_strobe_sync #(.STAGES(SYNC_STAGES), .NSIG(NSTRB)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({hp_cs_n, hp_rd_n, hp_wr_n}),
    .sync_o  (strb_s)
  );

  assign rd_act = ~strb_s[2] & ~strb_s[1];
  assign wr_act = ~strb_s[2] & ~strb_s[0];

  // Address and data are captured while the synchronised strobe is active
  always_comb begin
    cap_addr_d = cap_addr_q;
    cap_din_d  = cap_din_q;
    if (rd_act || wr_act) cap_addr_d = hp_addr;
    if (wr_act)           cap_din_d  = hp_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act_q   <= 1'b0;
      wr_act_q   <= 1'b0;
      cap_addr_q <= '0;
      cap_din_q  <= '0;
    end else begin
      rd_act_q   <= rd_act;
      wr_act_q   <= wr_act;
      cap_addr_q <= cap_addr_d;
      cap_din_q  <= cap_din_d;
    end
  end

  // An access completes on the release edge of its strobe
  assign h_rd_evt = rd_act_q & ~rd_act;
  assign h_wr_evt = wr_act_q & ~wr_act;
  assign h_sel    = hsel_e'(cap_addr_q);
  assign h_wdata  = lane_swap(cap_din_q, swap_mode);

  hpi_mem_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_wr   (h_wr_evt && (h_sel == HSEL_DATA)),
    .data_rd   (h_rd_evt && (h_sel == HSEL_DATA)),
    .ptr_wr    (h_wr_evt && (h_sel == HSEL_PTR)),
    .wdata     (h_wdata),
    .ptr       (ptr),
    .rd_buf    (rd_buf),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  hpi_mbox_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .h_mbx_wr     (h_wr_evt && (h_sel == HSEL_MBX)),
    .h_mbx_rd     (h_rd_evt && (h_sel == HSEL_MBX)),
    .h_stat_rd    (h_rd_evt && (h_sel == HSEL_STAT)),
    .h_wdata      (h_wdata),
    .cpu_wr       (cpu_wr),
    .cpu_rd       (cpu_rd),
    .cpu_idx      (cpu_idx),
    .cpu_wdata    (cpu_wdata),
    .cpu_rdata    (cpu_rdata),
    .vbus_evt     (vbus_evt),
    .out_mbx      (out_mbx),
    .stat_word    (stat_word),
    .swap_mode    (swap_mode),
    .route_on     (route_on),
    .hp_irq       (hp_irq),
    .cpu_mbx_irq  (cpu_mbx_irq),
    .cpu_txe_irq  (cpu_txe_irq),
    .cpu_vbus_irq (cpu_vbus_irq)
  );

  // Read data follows the raw address pins so it is valid during the strobe
  always_comb begin
    case (hsel_e'(hp_addr))
      HSEL_DATA: rmux = rd_buf;
      HSEL_MBX:  rmux = out_mbx;
      HSEL_PTR:  rmux = 16'(ptr);
      default:   rmux = stat_word;
    endcase
  end

  assign hp_dout    = lane_swap(rmux, swap_mode);
  assign hp_dout_en = ~hp_cs_n & ~hp_rd_n;

endmodule

// File: rtl/hpi_mbox_chk.sv
module hpi_mbox_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hp_cs_n,
  input logic          hp_dout_en,
  input logic          hp_irq,
  input logic          cpu_wr,
  input logic          cpu_rd,
  input logic [2:0]    cpu_idx,
  input logic          cpu_mbx_irq,
  input logic          cpu_txe_irq,
  input logic          cpu_vbus_irq,
  input logic          vbus_evt,
  input logic          route_on,
  input logic          mem_we,
  input logic          mem_re,
  input logic          h_wr_evt,
  input logic          h_rd_evt,
  input logic [1:0]    h_sel,
  input logic [AW-1:0] ptr
);

  // R4
  outbox_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_idx == 3'd0) |=> hp_irq);

  // R5
  txe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_idx == 3'd0) |=> !cpu_txe_irq);

  // R6
  inbox_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr_evt && h_sel == 2'd1) |=> cpu_mbx_irq);

  // R6
  inbox_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_idx == 3'd1 && !(h_wr_evt && h_sel == 2'd1)) |=> !cpu_mbx_irq);

  // R2
  data_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr_evt && h_sel == 2'd0) |-> mem_we);

  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((h_wr_evt || h_rd_evt) && h_sel == 2'd0) |=> (ptr == AW'($past(ptr) + 1'b1)));

  // R2
  mem_single_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R10
  dout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hp_cs_n |-> !hp_dout_en);

  // R9
  vbus_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vbus_evt && route_on) |=> hp_irq);

  // R9
  vbus_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vbus_evt && !route_on) |=> cpu_vbus_irq);

endmodule

bind hpi_mbox_top hpi_mbox_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_hpi_mbox_top.sv
`timescale 1ns/1ps
module tb_hpi_mbox_top;

  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic          clk, rst_n;
  logic          hp_cs_n, hp_rd_n, hp_wr_n;
  logic [1:0]    hp_addr;
  logic [15:0]   hp_din, hp_dout;
  logic          hp_dout_en, hp_irq;
  logic [AW-1:0] mem_addr;
  logic          mem_we, mem_re;
  logic [15:0]   mem_wdata, mem_rdata;
  logic          cpu_wr, cpu_rd;
  logic [2:0]    cpu_idx;
  logic [15:0]   cpu_wdata, cpu_rdata;
  logic          cpu_mbx_irq, cpu_txe_irq, cpu_vbus_irq, vbus_evt;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [15:0] mem_m [DEPTH];
  logic [15:0] sh    [DEPTH];

  hpi_mbox_top #(.AW(AW)) dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) mem_m[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem_m[mem_addr];
  end

  function automatic logic [15:0] seed_word(input int i);
    return 16'(i * 37) ^ 16'h5a5a;
  endfunction

  function automatic logic [15:0] swp(input logic [1:0] m, input logic [15:0] w);
    if (m == 2'b11) return {w[7:0], w[15:8]};
    return w;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    hp_addr = a; hp_din = d; hp_cs_n = 1'b0;
    @(negedge clk); hp_wr_n = 1'b0;
    repeat (4) @(negedge clk);
    hp_wr_n = 1'b1;
    repeat (4) @(negedge clk);
    hp_cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic host_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    hp_addr = a; hp_cs_n = 1'b0;
    @(negedge clk); hp_rd_n = 1'b0;
    repeat (4) @(negedge clk);
    d = hp_dout;
    hp_rd_n = 1'b1;
    repeat (4) @(negedge clk);
    hp_cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic cpu_write(input logic [2:0] i, input logic [15:0] d);
    @(negedge clk);
    cpu_idx = i; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [2:0] i, output logic [15:0] d);
    @(negedge clk);
    cpu_idx = i; cpu_rd = 1'b1;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic vbus_pulse();
    @(negedge clk); vbus_evt = 1'b1;
    @(negedge clk); vbus_evt = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic [1:0]  mode;
    int          eptr, seed, bad;
    for (int i = 0; i < DEPTH; i++) begin
      mem_m[i] = seed_word(i);
      sh[i]    = seed_word(i);
    end
    rst_n = 1'b0; hp_cs_n = 1'b1; hp_rd_n = 1'b1; hp_wr_n = 1'b1;
    hp_addr = '0; hp_din = '0; cpu_wr = 1'b0; cpu_rd = 1'b0;
    cpu_idx = '0; cpu_wdata = '0; vbus_evt = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk("R11 hp_irq", 16'(hp_irq), 16'h0);
    chk("R11 cpu_mbx_irq", 16'(cpu_mbx_irq), 16'h0);
    chk("R11 cpu_txe_irq", 16'(cpu_txe_irq), 16'h0);
    chk("R11 cpu_vbus_irq", 16'(cpu_vbus_irq), 16'h0);
    chk("R11 hp_dout_en", 16'(hp_dout_en), 16'h0);
    host_read(2'b10, r); chk("R11 pointer", r, 16'h0);
    host_read(2'b11, r); chk("R11 status", r, 16'h0);
    cpu_read(3'd3, r);   chk("R11 control", r, 16'h0);

    // R1 / R2 / R3 pointer and data window, with wrap
    host_write(2'b10, 16'h03FE);
    host_read(2'b10, r);  chk("R1 pointer readback", r, 16'h03FE);
    host_read(2'b00, r);  chk("R3 data at 3FE", r, sh[16'h3FE]);
    host_read(2'b10, r);  chk("R2 step after read", r, 16'h03FF);
    host_write(2'b00, 16'h1111); sh[16'h3FF] = 16'h1111;
    host_read(2'b10, r);  chk("R2 wrap to zero", r, 16'h0000);
    chk("R2 stored word", mem_m[16'h3FF], 16'h1111);
    host_write(2'b10, 16'h03FF);
    host_read(2'b00, r);  chk("R3 read after load", r, 16'h1111);

    // R4 / R5 outbound mailbox and transmit empty
    cpu_write(3'd0, 16'hBEEF);
    chk("R4 hp_irq raised", 16'(hp_irq), 16'h1);
    host_read(2'b11, r);  chk("R7 outbound bit", r, 16'h0001);
    host_read(2'b01, r);  chk("R4 mailbox word", r, 16'hBEEF);
    chk("R4 hp_irq cleared", 16'(hp_irq), 16'h0);
    chk("R5 txe set", 16'(cpu_txe_irq), 16'h1);
    cpu_write(3'd0, 16'h0102);
    chk("R5 txe cleared", 16'(cpu_txe_irq), 16'h0);
    host_read(2'b01, r);  chk("R4 second word", r, 16'h0102);

    // R6 inbound mailbox
    host_write(2'b01, 16'h1234);
    chk("R6 mbx irq", 16'(cpu_mbx_irq), 16'h1);
    host_read(2'b11, r);  chk("R7 inbound bit", r, 16'h0002);
    cpu_read(3'd1, r);    chk("R6 inbound word", r, 16'h1234);
    @(negedge clk);
    chk("R6 mbx irq cleared", 16'(cpu_mbx_irq), 16'h0);

    // R7 message flag
    cpu_write(3'd2, 16'hAAAA);
    host_read(2'b11, r);  chk("R7 message bit", r, 16'h0004);
    host_read(2'b11, r);  chk("R7 message cleared", r, 16'h0000);

    // R8 byte lanes
    cpu_write(3'd3, 16'h0003);
    host_write(2'b10, 16'h1000);
    host_write(2'b00, 16'hA1B2); sh[16] = 16'hB2A1;
    chk("R8 swapped store", mem_m[16], 16'hB2A1);
    host_read(2'b10, r);  chk("R8 swapped pointer read", r, 16'h1100);
    cpu_write(3'd3, 16'h0000);
    host_read(2'b10, r);  chk("R8 straight pointer read", r, 16'h0011);
    cpu_write(3'd3, 16'h0001);
    host_write(2'b10, 16'h0010);
    host_read(2'b00, r);  chk("R8 code 01 no swap", r, 16'hB2A1);
    cpu_write(3'd3, 16'h0002);
    host_write(2'b10, 16'h0010);
    host_read(2'b00, r);  chk("R8 code 10 no swap", r, 16'hB2A1);

    // R9 bus-voltage routing
    cpu_write(3'd3, 16'h0004);
    vbus_pulse();
    chk("R9 host irq", 16'(hp_irq), 16'h1);
    chk("R9 cpu irq idle", 16'(cpu_vbus_irq), 16'h0);
    host_read(2'b11, r);  chk("R9 status bit", r, 16'h0008);
    chk("R9 host irq cleared", 16'(hp_irq), 16'h0);
    cpu_write(3'd3, 16'h0000);
    vbus_pulse();
    chk("R9 cpu irq", 16'(cpu_vbus_irq), 16'h1);
    chk("R9 host irq idle", 16'(hp_irq), 16'h0);
    cpu_read(3'd4, r);
    @(negedge clk);
    chk("R9 cpu irq cleared", 16'(cpu_vbus_irq), 16'h0);

    // R10 strobes with chip select high
    @(negedge clk); hp_addr = 2'b01; hp_din = 16'h5555;
    @(negedge clk); hp_wr_n = 1'b0;
    repeat (4) @(negedge clk); hp_wr_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R10 ignored write", 16'(cpu_mbx_irq), 16'h0);
    cpu_write(3'd0, 16'h7777);
    @(negedge clk); hp_rd_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 no output enable", 16'(hp_dout_en), 16'h0);
    hp_rd_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R10 ignored read", 16'(hp_irq), 16'h1);
    host_read(2'b01, r);  chk("R4 mailbox after ignored read", r, 16'h7777);

    // Randomised data window traffic
    seed = $urandom(32'h00C0FFEE);
    mode = 2'b00;
    host_write(2'b10, 16'h0000);
    eptr = 0;
    for (int n = 0; n < 80; n++) begin
      int op;
      op = $urandom_range(0, 4);
      case (op)
        0: begin
          logic [15:0] v;
          v = 16'($urandom);
          host_write(2'b00, v);
          sh[eptr] = swp(mode, v);
          eptr = (eptr + 1) % DEPTH;
        end
        1: begin
          host_read(2'b00, r);
          chk("R3 random data read", r, swp(mode, sh[eptr]));
          eptr = (eptr + 1) % DEPTH;
        end
        2: begin
          int np;
          np = $urandom_range(0, DEPTH - 1);
          host_write(2'b10, swp(mode, 16'(np)));
          eptr = np;
        end
        3: begin
          host_read(2'b10, r);
          chk("R2 random pointer", r, swp(mode, 16'(eptr)));
        end
        default: begin
          mode = 2'($urandom_range(0, 3));
          cpu_write(3'd3, {14'b0, mode});
        end
      endcase
    end
    bad = 0;
    for (int i = 0; i < DEPTH; i++) if (mem_m[i] !== sh[i]) bad++;
    chk("R2 memory image", 16'(bad), 16'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule